// File: doc/BRIEF.md
# Sixteen-Bit Free-Running Timer

This block is a 16-bit up-counter that runs continuously from a divided version of the system clock. Software controls it through a small byte-wide register port. One control byte selects the count rate, starts and stops counting, issues a one-shot clear, enables the overflow interrupt and holds a sticky overflow flag. The two count bytes can be read and written directly. The live count is also exported so that neighbouring units, such as capture logic, can sample it.

When the count wraps from its all-ones value to zero, the overflow flag is set and stays set until software writes a zero to it. If the interrupt enable is also set, the flag drives a level interrupt request. A read that belongs to a read-modify-write access always returns the flag as one. Because of this, writing the value back cannot clear an overflow by accident.

Top module: `frt16_unit`

## Requirements
- R1: After a synchronous reset the control byte (address 0) reads 00h, the count is 0000h and `irq` is low, so the timer runs at the fastest rate with the interrupt disabled.
- R2: Control bits 2:0 hold a rate code k. While the timer runs, the count rises by one every 2^(k+1) system clocks, from a divider that runs freely from reset.
- R3: Control bit 5 at 1 freezes the count. At 0 the count advances on each rate tick.
- R4: A wrap of the running count from FFFFh to 0000h sets the overflow flag (control bit 7). The flag stays set.
- R5: Writing the control byte with bit 7 at 0 clears the flag. Writing bit 7 at 1 leaves the flag unchanged.
- R6: A read of the control byte with `bus_rmw` high returns bit 7 as 1. A plain read returns the true flag.
- R7: `irq` is high exactly when the flag and the enable bit (control bit 6) are both 1.
- R8: A control write with bit 3 at 1 sets the count to 0000h at that edge. This happens only if the timer is running before the write and bit 5 of the written value is 0. Bit 3 always reads as 0, and bit 4 reads as 0.
- R9: A write to address 1 replaces the low count byte and a write to address 2 replaces the high count byte at that edge, whether the timer runs or not. No increment happens in that cycle. Both addresses read back the live byte.
- R10: If a clear or a count write falls on the edge where the count would wrap, the flag is not set. A software flag clear beats a simultaneous hardware set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when `bus_rd` is low |
| count_val | output | 16 | Live count for neighbouring units |
| irq | output | 1 | Level overflow interrupt request |

## Verification
A wrong divider phase or rate decode changes the spacing between count steps, and this is visible on `count_val` within one rate period. A stuck or wrongly prioritised flag shows on `irq` and on the control read in the cycle after the wrap edge or the software write. The directed races put a clear or a flag write on the exact wrap edge, so a priority error shows in the first read that follows.

// File: rtl/frt_pkg.sv
// Package: shared widths, register addresses and control bit positions
// for the free-running timer. Assumes a byte-wide register port.
package frt_pkg;
    localparam int CNT_W     = 16;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int SEL_W     = 3;
    localparam int NLANE     = CNT_W / DATA_W;

    // Register addresses; count lanes follow the control byte in order.
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_CNT_BASE = 1;

    // Control byte bit positions (software depends on them).
    localparam int B_OVF  = 7;
    localparam int B_IE   = 6;
    localparam int B_STOP = 5;
    localparam int B_RSV  = 4;
    localparam int B_CLR  = 3;

    typedef struct packed {
        logic             ovf_ie;
        logic             stop;
        logic [SEL_W-1:0] rate_sel;
    } ctrl_t;
endpackage

// File: rtl/frt_prescaler.sv
// Prescaler: a free-running divider that emits a one-cycle tick every
// 2^(rate_sel+1) clocks. Assumes the divider is never reset except by rst_n.
module frt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick
);
    localparam int DIV_W = 2 ** SEL_W;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + DIV_W'(1);
    end

    // Mask of the low rate_sel+1 divider bits.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i <= int'(rate_sel));
        end
    end

    // Tick when all masked bits are ones.
    assign tick = ((div_cnt & mask) == mask);
endmodule

// File: rtl/frt_ctrl_reg.sv
// Control register: holds enable, stop, rate code and the sticky overflow
// flag, and decodes the one-shot clear. Assumes ctrl_wr lasts one cycle.
module frt_ctrl_reg
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf_set,
    output ctrl_t             ctrl,
    output logic              ovf_flag,
    output logic              clr_go
);
    // The clear acts only when the timer runs before and after the write.
    assign clr_go = ctrl_wr && wdata[B_CLR] && !wdata[B_STOP] && !ctrl.stop;

    // Writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.ovf_ie   <= wdata[B_IE];
            ctrl.stop     <= wdata[B_STOP];
            ctrl.rate_sel <= wdata[SEL_W-1:0];
        end
    end

    // Sticky flag: a software zero write beats a hardware set.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_flag <= 1'b0;
        else if (ctrl_wr && !wdata[B_OVF]) ovf_flag <= 1'b0;
        else if (ovf_set)                ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/frt_counter.sv
// Count register: loads byte lanes, clears, or increments on a rate tick
// while running, and reports a wrap. Priority: clear, lane load, increment.
module frt_counter #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              stop,
    input  logic              clr_go,
    input  logic [CNT_W/DATA_W-1:0] lane_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    localparam int NLANE = CNT_W / DATA_W;

    logic [CNT_W-1:0] nxt;

    // Next count and wrap detection.
    always_comb begin
        nxt  = count;
        wrap = 1'b0;
        if (clr_go) begin
            nxt = '0;
        end else if (|lane_wr) begin
            for (int l = 0; l < NLANE; l++) begin
                if (lane_wr[l]) nxt[l*DATA_W +: DATA_W] = wdata;
            end
        end else if (tick && !stop) begin
            nxt  = count + CNT_W'(1);
            wrap = &count;
        end
    end

    // Count storage.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end
endmodule

// File: rtl/frt16_unit.sv
// Top of the free-running timer: register decode, read mux and interrupt.
// Assumes single-cycle strobes and combinational read data.
module frt16_unit
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  count_val,
    output logic              irq
);
    ctrl_t             ctrl;
    logic              ovf_flag;
    logic              clr_go;
    logic              tick;
    logic              wrap;
    logic              ctrl_wr;
    logic [NLANE-1:0]  lane_wr;
    logic [NLANE-1:0]  lane_sel;
    logic [DATA_W-1:0] ctrl_byte;
    logic              unused_rsv;

    // The reserved write bit is not stored.
    assign unused_rsv = bus_wdata[B_RSV];

    // Control write decode.
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));

    // Per-lane address decode for count bytes.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_sel[g] = (bus_addr == ADDR_W'(ADDR_CNT_BASE + g));
        assign lane_wr[g]  = bus_wr && lane_sel[g];
    end

    frt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (ctrl.rate_sel),
        .tick     (tick)
    );

    frt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wdata    (bus_wdata),
        .ovf_set  (wrap),
        .ctrl     (ctrl),
        .ovf_flag (ovf_flag),
        .clr_go   (clr_go)
    );

    frt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .stop    (ctrl.stop),
        .clr_go  (clr_go),
        .lane_wr (lane_wr),
        .wdata   (bus_wdata),
        .count   (count_val),
        .wrap    (wrap)
    );

    // Control byte image; flag forced high on read-modify-write reads.
    always_comb begin
        ctrl_byte             = '0;
        ctrl_byte[B_OVF]      = ovf_flag || bus_rmw;
        ctrl_byte[B_IE]       = ctrl.ovf_ie;
        ctrl_byte[B_STOP]     = ctrl.stop;
        ctrl_byte[SEL_W-1:0]  = ctrl.rate_sel;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(ADDR_CTRL)) bus_rdata = ctrl_byte;
            for (int l = 0; l < NLANE; l++) begin
                if (lane_sel[l]) bus_rdata = count_val[l*DATA_W +: DATA_W];
            end
        end
    end

    // Level interrupt request.
    assign irq = ovf_flag && ctrl.ovf_ie;
endmodule

// File: rtl/frt16_chk.sv
// Checker for the free-running timer; bound to the top module below.
module frt16_chk
    import frt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_rmw,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  count_val,
    input logic              irq,
    input logic              tick,
    input logic              stop,
    input logic              ovf_flag,
    input logic              ovf_ie,
    input logic              wrap,
    input logic              clr_go
);
    logic c_ctrl_wr;
    logic c_cnt_wr;
    logic c_sw_clr;

    assign c_ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign c_cnt_wr  = bus_wr && (bus_addr >= ADDR_W'(ADDR_CNT_BASE))
                              && (bus_addr <  ADDR_W'(ADDR_CNT_BASE + NLANE));
    assign c_sw_clr  = c_ctrl_wr && !bus_wdata[B_OVF];

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_stop_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !c_cnt_wr) |=> $stable(count_val));

    p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !c_sw_clr) |=> ovf_flag);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !c_sw_clr) |=> ovf_flag);

    p_sw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c_sw_clr |=> !ovf_flag);

    p_rmw_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_rmw && bus_addr == ADDR_W'(ADDR_CTRL)) |-> bus_rdata[B_OVF]);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && ovf_ie));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (count_val == '0));
endmodule

bind frt16_unit frt16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rmw   (bus_rmw),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count_val (count_val),
    .irq       (irq),
    .tick      (tick),
    .stop      (ctrl.stop),
    .ovf_flag  (ovf_flag),
    .ovf_ie    (ctrl.ovf_ie),
    .wrap      (wrap),
    .clr_go    (clr_go)
);

// File: tb/frt16_unit_tb_top.sv
// Directed bench for the free-running timer: one task per scenario.
module frt16_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_rmw = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] count_val;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frt16_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rmw(bus_rmw), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_val(count_val), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic wait_change(output int at);
        logic [15:0] prev;
        prev = count_val;
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (count_val !== prev) begin
                at = cyc;
                return;
            end
        end
    endtask

    // Load the count with the timer stopped and the flag cleared.
    task automatic preload(input logic [15:0] v);
        wr(2'd0, 8'h20);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 count", count_val, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        rd(2'd0, 1'b0, d);
        chk("R1 ctrl", {8'd0, d}, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_prescale;
        int a, b, c;
        for (int s = 0; s < 8; s++) begin
            wr(2'd0, 8'h80 | 8'(s));
            wait_change(a);
            wait_change(b);
            wait_change(c);
            chk($sformatf("R2 period code %0d", s), 16'(c - b), 16'(2 ** (s + 1)));
        end
    endtask

    task automatic t_stop;
        logic [15:0] held;
        int a;
        wr(2'd0, 8'h20);
        held = count_val;
        repeat (60) @(negedge clk);
        chk("R3 held while stopped", count_val, held);
        wr(2'd0, 8'h00);
        wait_change(a);
        chk("R3 resumes", 16'(a > 0), 16'd1);
    endtask

    task automatic t_direct;
        logic [7:0]  d;
        logic [15:0] prev;
        preload(16'h1234);
        chk("R9 stopped load", count_val, 16'h1234);
        rd(2'd1, 1'b0, d);
        chk("R9 read low", {8'd0, d}, 16'h0034);
        rd(2'd2, 1'b0, d);
        chk("R9 read high", {8'd0, d}, 16'h0012);
        wr(2'd0, 8'h00);
        repeat (3) @(negedge clk);
        prev = count_val;
        bus_addr = 2'd2; bus_wdata = 8'hAB; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 running high load", count_val, {8'hAB, prev[7:0]});
    endtask

    task automatic t_clear;
        logic [7:0]  d;
        logic [15:0] prev;
        wr(2'd0, 8'h00);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h08);
        chk("R8 clear while running", count_val, 16'h0000);
        rd(2'd0, 1'b0, d);
        chk("R8 clear bit reads 0", {8'd0, d}, 16'h0000);
        preload(16'h0555);
        prev = count_val;
        wr(2'd0, 8'h08);
        chk("R8 clear ignored when stopped", count_val, prev);
        wr(2'd0, 8'h30);
        rd(2'd0, 1'b0, d);
        chk("R8 reserved and clear read 0", {8'd0, d}, 16'h0020);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        preload(16'hFFFE);
        wr(2'd0, 8'hC0);
        for (int i = 0; i < 20 && count_val != 16'h0000; i++) @(negedge clk);
        rd(2'd0, 1'b0, d);
        chk("R4 flag set on wrap", {15'd0, d[7]}, 16'd1);
        chk("R7 irq with enable", {15'd0, irq}, 16'd1);
        wr(2'd0, 8'h80);
        chk("R7 irq off without enable", {15'd0, irq}, 16'd0);
        rd(2'd0, 1'b0, d);
        chk("R5 write one keeps flag", {15'd0, d[7]}, 16'd1);
        wr(2'd0, 8'h40);
        rd(2'd0, 1'b0, d);
        chk("R5 write zero clears flag", {15'd0, d[7]}, 16'd0);
        chk("R7 irq low after clear", {15'd0, irq}, 16'd0);
        rd(2'd0, 1'b1, d);
        chk("R6 rmw read returns one", {15'd0, d[7]}, 16'd1);
        wr(2'd0, 8'hC0);
        rd(2'd0, 1'b0, d);
        chk("R5 write one does not set", {15'd0, d[7]}, 16'd0);
    endtask

    // Put a control write on the exact wrap edge (rate code 0).
    task automatic t_race(input logic [7:0] cmd, input string tag);
        logic [7:0] d;
        preload(16'hFFFE);
        wr(2'd0, 8'h80);
        for (int i = 0; i < 20 && count_val != 16'hFFFF; i++) @(negedge clk);
        wr(2'd0, cmd);
        chk({tag, " count"}, count_val, 16'h0000);
        rd(2'd0, 1'b0, d);
        chk({tag, " flag"}, {15'd0, d[7]}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_stop();
        t_direct();
        t_clear();
        t_overflow();
        t_race(8'hC8, "R10 clear beats wrap");
        t_race(8'h40, "R10 sw clear beats set");
        chk("R10 irq after races", {15'd0, irq}, 16'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule